// File: doc/BRIEF.md
# Software Recall Sequence Controller

This block watches the chip-enable, output-enable, write-enable and address pins of an asynchronous SRAM-style port, sampled on the system clock. It looks for one exact series of six read cycles. When the last read of the series is seen, it starts a recall of the nonvolatile image into the volatile array. The first two addresses of the series are parameters. The remaining four are fixed: 0x0AAA, then 0x1FFF, then 0x10F0, and finally 0x0F0E. The final read is the one that starts the recall.

The recall has two phases. A single-cycle clear strobe tells the array model to wipe its volatile contents. After that, a copy strobe is pulsed once for every word, with the word address rising from zero, so that the array model can load each word from its nonvolatile image. The recall never writes to the nonvolatile side, so it can be repeated any number of times. A busy flag covers the whole recall window, which is a fixed number of clocks. While busy is high, the gated read and write enables stay low and bus activity is ignored.

Top module: `swrc_top`

## Requirements
- R1: While reset is asserted, and immediately after it is released, busy, clear strobe and copy strobe are all low.
- R2: Six read cycles to STEP0 (default 0x0E38), STEP1 (default 0x31C7), 0x0AAA, 0x1FFF, 0x10F0 and 0x0F0E, in that order, start a recall. Busy is high at the first clock edge after the edge that samples the final read.
- R3: A read cycle is counted once, on the clock where ce_n is first sampled low (it was high at the previous edge) while we_n is high. The address is taken from that same clock. Holding ce_n low for several clocks does not count the read again.
- R4: A counted read whose address does not equal the next expected step returns the matcher to its idle state. The whole series must then be repeated.
- R5: Any clock with ce_n and we_n both low while not busy returns the matcher to idle.
- R6: The clear strobe is high for exactly one clock, and that clock is the first clock of busy.
- R7: After the clear strobe, the copy strobe is high for WORDS consecutive clocks. copy_addr runs from 0 to WORDS-1 in ascending order during those clocks.
- R8: Busy stays high for exactly RECALL_CYCLES clocks per recall. Both strobes are high only while busy is high.
- R9: While busy is high, rd_ok and wr_ok are low and reads do not advance the matcher. After busy falls, a fresh full series starts a recall again.
- R10: When not busy, rd_ok equals (ce_n low, oe_n low, we_n high) and wr_ok equals (ce_n low, we_n low), combinationally from the pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, synchronous to clk |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address bus |
| busy | output | 1 | Recall in progress |
| rd_ok | output | 1 | Array read allowed this cycle |
| wr_ok | output | 1 | Array write allowed this cycle |
| clr_stb | output | 1 | Volatile clear phase strobe |
| copy_stb | output | 1 | Nonvolatile-to-volatile copy strobe |
| copy_addr | output | $clog2(WORDS) | Word being copied |

## Verification
The inline assertions check properties that must hold on every clock. They cover the one-cycle clear strobe and its position at the rise of busy, the clear-then-copy hand-off, the ascending copy address, the strobes staying inside busy, the gating of rd_ok and wr_ok, single counting of each read, and the return to idle after a write or a mismatched read. Other behaviours can only be shown by the bench scenarios: that only the exact six-address series starts a recall, that reads made during busy leave no partial progress behind, the exact length of busy and of the copy walk, and that a second recall follows a second series.

// File: rtl/swrc_pkg.sv
package swrc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CLEAR = 2'd1,
        PH_COPY  = 2'd2,
        PH_HOLD  = 2'd3
    } rc_phase_e;

    localparam int unsigned NUM_STEPS = 6;
    localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

    typedef struct packed {
        logic ce_prev;
    } acc_state_t;

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } match_state_t;
endpackage

// File: rtl/swrc_access_det.sv
module swrc_access_det
    import swrc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    output logic rd_start,
    output logic wr_seen
);
    acc_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.ce_prev = ce_n;
        rd_start     = !ce_n && st_q.ce_prev && we_n;
        wr_seen      = !ce_n && !we_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ce_prev: 1'b1};
        else        st_q <= st_d;
    end

    AST_READ_COUNTED_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start); // R3
endmodule

// File: rtl/swrc_seq_match.sv
module swrc_seq_match
    import swrc_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter logic [ADDR_W-1:0] STEP0 = 14'h0E38,
    parameter logic [ADDR_W-1:0] STEP1 = 14'h31C7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic              wr_seen,
    input  logic              hold,
    input  logic [ADDR_W-1:0] addr,
    output logic              fire
);
    localparam int unsigned LAST = NUM_STEPS - 1;

    function automatic logic [ADDR_W-1:0] step_addr(input int unsigned idx);
        case (idx)
            0:       step_addr = STEP0;
            1:       step_addr = STEP1;
            2:       step_addr = ADDR_W'(16'h0AAA);
            3:       step_addr = ADDR_W'(16'h1FFF);
            4:       step_addr = ADDR_W'(16'h10F0);
            default: step_addr = ADDR_W'(16'h0F0E);
        endcase
    endfunction

    logic [NUM_STEPS-1:0] hit;

    for (genvar gi = 0; gi < NUM_STEPS; gi++) begin : g_cmp
        assign hit[gi] = (addr == step_addr(gi));
    end

    match_state_t st_d, st_q;
    logic         cur_hit;

    always_comb begin
        st_d    = st_q;
        fire    = 1'b0;
        cur_hit = hit[st_q.step];
        if (!hold) begin
            if (wr_seen) begin
                st_d.step = '0;
            end else if (rd_start) begin
                if (!cur_hit) begin
                    st_d.step = '0;
                end else if (st_q.step == STEP_W'(LAST)) begin
                    st_d.step = '0;
                    fire      = 1'b1;
                end else begin
                    st_d.step = st_q.step + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{step: '0};
        else        st_q <= st_d;
    end

    AST_WRITE_CLEARS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_seen && !hold) |=> (st_q.step == '0)); // R5
    AST_MISMATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !wr_seen && !hold && !hit[st_q.step]) |=> (st_q.step == '0)); // R4
    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.step <= STEP_W'(LAST)); // R2
    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(st_q.step)); // R9
endmodule

// File: rtl/swrc_recall_seq.sv
module swrc_recall_seq
    import swrc_pkg::*;
#(
    parameter int unsigned WORDS         = 64,
    parameter int unsigned RECALL_CYCLES = 80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    output logic                     busy,
    output logic                     clr_stb,
    output logic                     copy_stb,
    output logic [$clog2(WORDS)-1:0] copy_addr
);
    localparam int unsigned CW = $clog2(RECALL_CYCLES + 1);
    localparam int unsigned AW = $clog2(WORDS);

    typedef struct packed {
        rc_phase_e     ph;
        logic [CW-1:0] cnt;
        logic [AW-1:0] wa;
    } rc_state_t;

    rc_state_t st_d, st_q;
    logic      cnt_end;

    always_comb begin
        st_d    = st_q;
        cnt_end = (st_q.cnt == CW'(RECALL_CYCLES - 1));
        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph  = PH_CLEAR;
                    st_d.cnt = '0;
                    st_d.wa  = '0;
                end
            end
            PH_CLEAR: begin
                st_d.ph  = PH_COPY;
                st_d.cnt = st_q.cnt + 1'b1;
            end
            PH_COPY: begin
                if (st_q.wa == AW'(WORDS - 1)) begin
                    st_d.ph = cnt_end ? PH_IDLE : PH_HOLD;
                end else begin
                    st_d.wa = st_q.wa + 1'b1;
                end
                if (!cnt_end) st_d.cnt = st_q.cnt + 1'b1;
            end
            default: begin
                if (cnt_end) st_d.ph  = PH_IDLE;
                else         st_d.cnt = st_q.cnt + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, cnt: '0, wa: '0};
        else        st_q <= st_d;
    end

    assign busy      = (st_q.ph != PH_IDLE);
    assign clr_stb   = (st_q.ph == PH_CLEAR);
    assign copy_stb  = (st_q.ph == PH_COPY);
    assign copy_addr = st_q.wa;

    AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> !clr_stb); // R6
    AST_CLEAR_AT_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> clr_stb); // R6
    AST_CLEAR_THEN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> (copy_stb && copy_addr == '0)); // R7
    AST_COPY_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_stb && $past(copy_stb)) |-> (copy_addr == $past(copy_addr) + 1'b1)); // R7
    AST_STROBES_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb || copy_stb) |-> busy); // R8
endmodule

// File: rtl/swrc_top.sv
module swrc_top
    import swrc_pkg::*;
#(
    parameter int unsigned ADDR_W        = 14,
    parameter logic [ADDR_W-1:0] STEP0   = 14'h0E38,
    parameter logic [ADDR_W-1:0] STEP1   = 14'h31C7,
    parameter int unsigned WORDS         = 64,
    parameter int unsigned RECALL_CYCLES = 80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ce_n,
    input  logic                     oe_n,
    input  logic                     we_n,
    input  logic [ADDR_W-1:0]        addr,
    output logic                     busy,
    output logic                     rd_ok,
    output logic                     wr_ok,
    output logic                     clr_stb,
    output logic                     copy_stb,
    output logic [$clog2(WORDS)-1:0] copy_addr
);
    logic rd_start;
    logic wr_seen;
    logic fire;

    swrc_access_det u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .rd_start (rd_start),
        .wr_seen  (wr_seen)
    );

    swrc_seq_match #(
        .ADDR_W (ADDR_W),
        .STEP0  (STEP0),
        .STEP1  (STEP1)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_start (rd_start),
        .wr_seen  (wr_seen),
        .hold     (busy),
        .addr     (addr),
        .fire     (fire)
    );

    swrc_recall_seq #(
        .WORDS         (WORDS),
        .RECALL_CYCLES (RECALL_CYCLES)
    ) u_recall (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fire),
        .busy      (busy),
        .clr_stb   (clr_stb),
        .copy_stb  (copy_stb),
        .copy_addr (copy_addr)
    );

    assign rd_ok = !busy && !ce_n && !oe_n && we_n;
    assign wr_ok = !busy && !ce_n && !we_n;

    AST_BUSY_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!rd_ok && !wr_ok)); // R9
    AST_FIRE_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> busy); // R2
endmodule

// File: tb/swrc_top_tb.sv
`timescale 1ns/1ps
module swrc_top_tb;
    localparam int WORDS = 64;
    localparam int RC    = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [13:0] addr = '0;
    logic        busy, rd_ok, wr_ok, clr_stb, copy_stb;
    logic [5:0]  copy_addr;

    int checks = 0;
    int fails  = 0;
    int n_clr = 0, n_copy = 0, n_busy = 0;
    int seqv [6] = '{'h0E38, 'h31C7, 'h0AAA, 'h1FFF, 'h10F0, 'h0F0E};

    // reference model state
    bit m_busy = 0;
    bit m_prev = 1;
    int m_el = 0;
    int m_step = 0;

    always #2.5 clk = ~clk;

    swrc_top u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .busy(busy), .rd_ok(rd_ok), .wr_ok(wr_ok),
        .clr_stb(clr_stb), .copy_stb(copy_stb), .copy_addr(copy_addr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_prev = 1; m_el = 0; m_step = 0;
        end else begin
            if (m_busy) begin
                if (m_el == RC - 1) m_busy = 0;
                else m_el++;
            end else if (!ce_n && !we_n) begin
                m_step = 0;
            end else if (!ce_n && m_prev && we_n) begin
                if (int'(addr) == seqv[m_step]) begin
                    if (m_step == 5) begin
                        m_busy = 1; m_el = 0; m_step = 0;
                    end else m_step++;
                end else m_step = 0;
            end
            m_prev = ce_n;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit e_clr, e_copy, e_rd, e_wr;
            e_clr  = m_busy && (m_el == 0);
            e_copy = m_busy && (m_el >= 1) && (m_el <= WORDS);
            e_rd   = !m_busy && !ce_n && !oe_n && we_n;
            e_wr   = !m_busy && !ce_n && !we_n;
            chk(busy == m_busy, "R8 busy", busy, m_busy);
            chk(clr_stb == e_clr, "R6 clr_stb", clr_stb, e_clr);
            chk(copy_stb == e_copy, "R7 copy_stb", copy_stb, e_copy);
            if (e_copy) chk(int'(copy_addr) == m_el - 1, "R7 copy_addr", copy_addr, m_el - 1);
            chk(rd_ok == e_rd, "R10 rd_ok", rd_ok, e_rd);
            chk(wr_ok == e_wr, "R10 wr_ok", wr_ok, e_wr);
            if (busy) chk(!rd_ok && !wr_ok, "R9 gated", rd_ok | wr_ok, 0);
            n_clr  += clr_stb;
            n_copy += copy_stb;
            n_busy += busy;
        end
    end

    task automatic rd(input int a, input int hold);
        @(negedge clk); #1;
        ce_n = 0; we_n = 1; oe_n = 0; addr = 14'(a);
        repeat (hold) @(negedge clk);
        #1; ce_n = 1; oe_n = 1;
        @(negedge clk);
    endtask

    task automatic wr(input int a);
        @(negedge clk); #1;
        ce_n = 0; we_n = 0; addr = 14'(a);
        @(negedge clk); #1;
        ce_n = 1; we_n = 1;
        @(negedge clk);
    endtask

    task automatic full_seq(input int hold);
        for (int i = 0; i < 6; i++) rd(seqv[i], hold);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        #750000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int c0, p0, b0;
        repeat (3) @(negedge clk);
        chk(!busy && !clr_stb && !copy_stb, "R1 in reset", busy | clr_stb | copy_stb, 0);
        #1 rst_n = 1;
        @(negedge clk);
        chk(!busy && !clr_stb && !copy_stb, "R1 after reset", busy | clr_stb | copy_stb, 0);

        // R2, R6, R7, R8: one recall, counted strobes
        c0 = n_clr; p0 = n_copy; b0 = n_busy;
        full_seq(1);
        chk(busy == 1, "R2 recall started", busy, 1);
        wait_idle();
        chk(n_clr - c0 == 1, "R6 clear count", n_clr - c0, 1);
        chk(n_copy - p0 == WORDS, "R7 copy count", n_copy - p0, WORDS);
        chk(n_busy - b0 == RC, "R8 busy length", n_busy - b0, RC);

        // R3: ce held low over several clocks still counts each read once
        full_seq(3);
        chk(busy == 1, "R3 held reads", busy, 1);
        wait_idle();

        // R3/R4: repeating a step address is a mismatch
        rd(seqv[0], 1); rd(seqv[0], 1);
        for (int i = 1; i < 6; i++) rd(seqv[i], 1);
        chk(busy == 0, "R4 repeated step", busy, 0);

        // R4: stray address in the middle
        rd(seqv[0], 1); rd(seqv[1], 1); rd(seqv[2], 1); rd('h0123, 1);
        rd(seqv[3], 1); rd(seqv[4], 1); rd(seqv[5], 1);
        chk(busy == 0, "R4 stray address", busy, 0);

        // R5: write before final step
        for (int i = 0; i < 5; i++) rd(seqv[i], 1);
        wr(seqv[5]);
        rd(seqv[5], 1);
        chk(busy == 0, "R5 write resets", busy, 0);

        // R9: reads during busy do not prime the matcher; recall repeatable
        full_seq(1);
        chk(busy == 1, "R9 busy again", busy, 1);
        rd(seqv[0], 1); rd(seqv[1], 1); rd(seqv[2], 1);
        chk(busy == 1, "R9 still busy", busy, 1);
        wait_idle();
        rd(seqv[3], 1); rd(seqv[4], 1); rd(seqv[5], 1);
        chk(busy == 0, "R9 no carry-over", busy, 0);
        full_seq(1);
        chk(busy == 1, "R9 repeat recall", busy, 1);
        wait_idle();

        // R10: plain access pass-through when idle
        @(negedge clk); #1; ce_n = 0; oe_n = 1; we_n = 1;
        @(negedge clk);
        chk(rd_ok == 0, "R10 oe high blocks read", rd_ok, 0);
        #1; ce_n = 1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule